// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Line Break

This block turns bytes written by a host into asynchronous serial frames on a single output line. Each accepted byte waits in a small queue until the framing engine is free. The engine then sends a low start bit, the data bits least significant first, an optional parity bit and one or two high stop bits. Every bit lasts sixteen pulses of an external oversampling tick, so one rate generator can serve both this block and a receiver.

A seven-bit line-control input sets the frame shape and the queue mode for every byte loaded after a change. It also carries a break bit that holds the line low for as long as it is set. Two status outputs tell the host when a further write would be lost and when the transmitter is still working. The host waits on the first before it writes and on the second before it reconfigures or powers down.

Top module: `uart_tx_brk`

## Requirements
- R1: A frame starts with one low start bit, then sends the data bits least significant first, then ends with a high stop bit. Each bit holds for 16 pulses of `baud_tick`.
- R2: `line_ctl[6:5]` sets the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits above the selected length are not sent.
- R3: When `line_ctl[1]` is 1, a parity bit follows the last data bit. With `line_ctl[2]` at 1 the parity is even, so the data bits and the parity bit hold an even number of ones. With `line_ctl[2]` at 0 the parity is odd.
- R4: When `line_ctl[3]` is 1, the frame ends with two stop bits, which makes it one bit time longer than the same frame with one stop bit.
- R5: When `line_ctl[4]` is 1, the queue holds up to 16 bytes and sends them in the order written. `tx_full` is 1 exactly while 16 bytes are stored.
- R6: When `line_ctl[4]` is 0, the queue holds a single byte, and `tx_full` is 1 while that byte is waiting.
- R7: A write made while `tx_full` is 1 is dropped. The bytes already stored are sent unchanged, and no extra frame appears.
- R8: `tx_busy` is 1 from the cycle after a write is accepted until the last stop bit has been sent and the queue is empty. It is 0 only when the transmitter is idle.
- R9: While `line_ctl[0]` is 1, `tx_out` is low, whatever the other inputs are.
- R10: When the break bit is clear, `tx_out` is high whenever `uart_en` is 0 or there is nothing to send. While `uart_en` is 0 no frame starts, and stored bytes stay queued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uart_en | input | 1 | Transmitter enable; 0 aborts a frame and holds the line idle |
| line_ctl | input | 7 | Line control: [0] break, [1] parity on, [2] even parity, [3] two stop bits, [4] 16-entry queue, [6:5] word length code |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| wr_valid | input | 1 | Write strobe for one byte |
| wr_char | input | 8 | Byte to queue |
| tx_out | output | 1 | Serial line |
| tx_full | output | 1 | Queue full; the next write is lost |
| tx_busy | output | 1 | Queue not empty or frame in progress |

## Verification
The bench decodes the serial line the way a receiver would and compares each decoded frame with a model built from the requirements. It covers every word length together with both parity senses. A design that used the wrong data bit as the parity input, or inverted the parity sense, would fail the parity check on at least one of these frames. Back-to-back frames with two stop bits are timed start to start, which catches an engine that skips the second stop bit or adds a gap of its own. The bench fills the queue in both modes and then writes once more while it is full. Here the queue must keep one byte in single-byte mode instead of sixteen, and it must not let a late write overwrite the oldest entry or add a seventeenth frame. The bench also drives break and disable while the queue holds data, so a line that goes low without being enabled, or a busy flag that drops while a byte is still stored, shows up at the ports.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int CTL_W       = 7;
  localparam int CTL_BREAK   = 0;
  localparam int CTL_PAR_ON  = 1;
  localparam int CTL_PAR_EVN = 2;
  localparam int CTL_STOP2   = 3;
  localparam int CTL_QUEUE   = 4;
  localparam int CTL_WLEN_LO = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;
endpackage

// File: rtl/uart_tx_queue.sv
module uart_tx_queue #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              deep_mode,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output logic              empty,
  output logic              full
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = deep_mode ? (cnt_q == CNT_W'(DEPTH)) : (cnt_q != '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head_data = mem[rd_ptr_q];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (do_push) wr_ptr_d = wr_ptr_q + 1'b1;
    if (do_pop)  rd_ptr_d = rd_ptr_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= push_data;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH)); // R5
  AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> $stable(cnt_q)); // R7
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic [1:0]        wlen,
  input  logic              par_on,
  input  logic              par_even,
  input  logic              stop2,
  input  logic              have_data,
  input  logic [DATA_W-1:0] data_in,
  output logic              take,
  output logic              active,
  output logic              line
);
  localparam int TCNT_W = $clog2(OSR);
  localparam int IDX_W  = $clog2(DATA_W);

  tx_state_e         state_q, state_d;
  logic [TCNT_W-1:0] tcnt_q, tcnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic              pbit_q, pbit_d;
  logic [1:0]        wlen_q, wlen_d;
  logic              pon_q, pon_d, stop2_q, stop2_d;
  logic              bit_end;
  logic [DATA_W-1:0] mask;

  assign bit_end = tick && (tcnt_q == TCNT_W'(OSR - 1));
  assign mask    = {DATA_W{1'b1}} >> (2'd3 - wlen);
  assign take    = en && (state_q == ST_IDLE) && have_data;
  assign active  = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    tcnt_d  = tick ? tcnt_q + 1'b1 : tcnt_q;
    idx_d   = idx_q;
    shreg_d = shreg_q;
    pbit_d  = pbit_q;
    wlen_d  = wlen_q;
    pon_d   = pon_q;
    stop2_d = stop2_q;
    case (state_q)
      ST_IDLE: begin
        tcnt_d = '0;
        if (take) begin
          state_d = ST_START;
          shreg_d = data_in;
          pbit_d  = (^(data_in & mask)) ^ !par_even;
          wlen_d  = wlen;
          pon_d   = par_on;
          stop2_d = stop2;
        end
      end
      ST_START: if (bit_end) begin
        state_d = ST_DATA;
        idx_d   = '0;
      end
      ST_DATA: if (bit_end) begin
        shreg_d = shreg_q >> 1;
        if (idx_q == IDX_W'(4 + wlen_q)) begin
          state_d = pon_q ? ST_PAR : ST_STOP;
          idx_d   = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_PAR: if (bit_end) begin
        state_d = ST_STOP;
        idx_d   = '0;
      end
      ST_STOP: if (bit_end) begin
        if (stop2_q && (idx_q == '0)) idx_d = IDX_W'(1);
        else                          state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    if (!en) state_d = ST_IDLE;
  end

  always_comb begin
    case (state_q)
      ST_START: line = 1'b0;
      ST_DATA:  line = shreg_q[0];
      ST_PAR:   line = pbit_q;
      default:  line = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tcnt_q  <= '0;
      idx_q   <= '0;
      shreg_q <= '0;
      pbit_q  <= 1'b0;
      wlen_q  <= '0;
      pon_q   <= 1'b0;
      stop2_q <= 1'b0;
    end else begin
      state_q <= state_d;
      tcnt_q  <= tcnt_d;
      idx_q   <= idx_d;
      shreg_q <= shreg_d;
      pbit_q  <= pbit_d;
      wlen_q  <= wlen_d;
      pon_q   <= pon_d;
      stop2_q <= stop2_d;
    end
  end

  AST_BIT_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && $past(state_q) != ST_IDLE && state_q != $past(state_q))
      |-> ($past(tick) && $past(tcnt_q) == TCNT_W'(OSR - 1))); // R1
  AST_LOAD_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (state_q == ST_START)); // R8
  AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(en) && $past(state_q) == ST_IDLE) |-> state_q == ST_IDLE); // R10
endmodule

// File: rtl/uart_tx_brk.sv
module uart_tx_brk
  import uart_tx_pkg::*;
#(
  parameter int QUEUE_DEPTH = 16,
  parameter int OSR         = 16,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uart_en,
  input  logic [CTL_W-1:0]  line_ctl,
  input  logic              baud_tick,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_char,
  output logic              tx_out,
  output logic              tx_full,
  output logic              tx_busy
);
  logic              q_empty, q_pop, frm_active, frm_line;
  logic [DATA_W-1:0] q_head;

  uart_tx_queue #(.DEPTH(QUEUE_DEPTH), .DATA_W(DATA_W)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .deep_mode (line_ctl[CTL_QUEUE]),
    .push      (wr_valid),
    .push_data (wr_char),
    .pop       (q_pop),
    .head_data (q_head),
    .empty     (q_empty),
    .full      (tx_full)
  );

  uart_tx_framer #(.OSR(OSR), .DATA_W(DATA_W)) u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (uart_en),
    .tick      (baud_tick),
    .wlen      (line_ctl[CTL_WLEN_LO +: 2]),
    .par_on    (line_ctl[CTL_PAR_ON]),
    .par_even  (line_ctl[CTL_PAR_EVN]),
    .stop2     (line_ctl[CTL_STOP2]),
    .have_data (!q_empty),
    .data_in   (q_head),
    .take      (q_pop),
    .active    (frm_active),
    .line      (frm_line)
  );

  assign tx_busy = frm_active || !q_empty;
  assign tx_out  = line_ctl[CTL_BREAK] ? 1'b0 : (uart_en ? frm_line : 1'b1);

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && !line_ctl[CTL_BREAK]) |-> tx_out); // R10
  AST_FULL_IS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full |-> tx_busy); // R8
endmodule

// File: tb/uart_tx_brk_bench.sv
module uart_tx_brk_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       uart_en = 1'b0;
  logic [6:0] line_ctl = 7'h70;
  logic       baud_tick = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_char = 8'h00;
  logic       tx_out, tx_full, tx_busy;
  int         n_chk = 0, n_bad = 0, cyc = 0;

  uart_tx_brk u_uart_tx_brk (
    .clk(clk), .rst_n(rst_n), .uart_en(uart_en), .line_ctl(line_ctl),
    .baud_tick(baud_tick), .wr_valid(wr_valid), .wr_char(wr_char),
    .tx_out(tx_out), .tx_full(tx_full), .tx_busy(tx_busy));

  always #4 clk = ~clk;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    baud_tick <= ((cyc % 4) == 3);
  end

  always @(negedge clk) begin
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    wr_valid = 1'b1; wr_char = b;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  function automatic logic [7:0] keep(input logic [7:0] b, input int nb);
    return b & 8'((1 << nb) - 1);
  endfunction

  task automatic rx_frame(input int nb, input bit pen, output logic [7:0] d,
                          output logic pb, output logic s1, output int t0);
    int w = 0;
    d = '0; pb = 1'b0; s1 = 1'b0; t0 = -1;
    while (tx_out !== 1'b0 && w < 3000) begin @(negedge clk); w++; end
    if (w >= 3000) begin chk(0, "R1 start bit seen", 1, 0); return; end
    t0 = cyc;
    repeat (32) @(negedge clk);
    chk(tx_out == 1'b0, "R1 start bit mid", tx_out, 0);
    for (int i = 0; i < nb; i++) begin
      repeat (64) @(negedge clk);
      d[i] = tx_out;
    end
    if (pen) begin repeat (64) @(negedge clk); pb = tx_out; end
    repeat (64) @(negedge clk);
    s1 = tx_out;
  endtask

  task automatic expect_quiet(input int n, input string req);
    bit low = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tx_out !== 1'b1) low = 1'b1;
    end
    chk(!low, req, low, 0);
  endtask

  task automatic t_reset;
    chk(tx_out == 1'b1, "R10 reset line high", tx_out, 1);
    chk(tx_full == 1'b0, "R5 reset not full", tx_full, 0);
    chk(tx_busy == 1'b0, "R8 reset not busy", tx_busy, 0);
  endtask

  task automatic t_basic;
    logic [7:0] d; logic pb, s1; int t0;
    line_ctl = 7'h70; uart_en = 1'b1;
    put(8'hA5);
    chk(tx_busy == 1'b1, "R8 busy after write", tx_busy, 1);
    rx_frame(8, 0, d, pb, s1, t0);
    chk(d == 8'hA5, "R1 data lsb first", d, 8'hA5);
    chk(s1 == 1'b1, "R1 stop high", s1, 1);
    chk(tx_busy == 1'b1, "R8 busy during stop", tx_busy, 1);
    repeat (80) @(negedge clk);
    chk(tx_busy == 1'b0, "R8 idle after frame", tx_busy, 0);
    chk(tx_out == 1'b1, "R10 idle line high", tx_out, 1);
  endtask

  task automatic t_wlen_parity;
    logic [7:0] d; logic pb, s1; int t0;
    logic [7:0] pat [4] = '{8'hD3, 8'h6B, 8'hF1, 8'h2C};
    uart_en = 1'b1;
    for (int wl = 0; wl < 4; wl++) begin
      int nb = 5 + wl;
      bit even = (wl % 2 == 0);
      logic exp_p;
      line_ctl = {2'(wl), 1'b1, 1'b0, 1'(even), 1'b1, 1'b0};
      put(pat[wl]);
      rx_frame(nb, 1, d, pb, s1, t0);
      exp_p = (^keep(pat[wl], nb)) ^ !even;
      chk(d == keep(pat[wl], nb), "R2 word length data", d, keep(pat[wl], nb));
      chk(pb == exp_p, "R3 parity bit", pb, exp_p);
      chk(s1 == 1'b1, "R3 stop after parity", s1, 1);
      repeat (100) @(negedge clk);
    end
  endtask

  task automatic t_stops;
    logic [7:0] d; logic pb, s1; int ta, tb, gap;
    uart_en = 1'b1;
    line_ctl = 7'h78;
    put(8'h11); put(8'h22);
    rx_frame(8, 0, d, pb, s1, ta);
    rx_frame(8, 0, d, pb, s1, tb);
    gap = tb - ta;
    chk(d == 8'h22, "R4 second frame data", d, 8'h22);
    chk(gap >= 700 && gap <= 712, "R4 two stop spacing", gap, 704);
    repeat (150) @(negedge clk);
    line_ctl = 7'h70;
    put(8'h33); put(8'h44);
    rx_frame(8, 0, d, pb, s1, ta);
    rx_frame(8, 0, d, pb, s1, tb);
    gap = tb - ta;
    chk(gap >= 636 && gap <= 648, "R1 one stop 16-tick bits", gap, 640);
    repeat (100) @(negedge clk);
  endtask

  task automatic t_queue16;
    logic [7:0] d; logic pb, s1; int t0, bad;
    uart_en = 1'b0; line_ctl = 7'h70;
    for (int i = 0; i < 15; i++) put(8'(8'h40 + i));
    chk(tx_full == 1'b0, "R5 not full at 15", tx_full, 0);
    put(8'h4F);
    chk(tx_full == 1'b1, "R5 full at 16", tx_full, 1);
    put(8'hEE);
    chk(tx_full == 1'b1, "R7 still full after drop", tx_full, 1);
    uart_en = 1'b1;
    bad = 0;
    for (int i = 0; i < 16; i++) begin
      rx_frame(8, 0, d, pb, s1, t0);
      if (d != 8'(8'h40 + i)) bad++;
    end
    chk(bad == 0, "R5 order of 16 bytes", bad, 0);
    expect_quiet(900, "R7 no extra frame");
    chk(tx_busy == 1'b0, "R8 idle after drain", tx_busy, 0);
  endtask

  task automatic t_hold;
    logic [7:0] d; logic pb, s1; int t0;
    uart_en = 1'b0; line_ctl = 7'h60;
    put(8'h5A);
    chk(tx_full == 1'b1, "R6 full after one byte", tx_full, 1);
    put(8'hC3);
    uart_en = 1'b1;
    rx_frame(8, 0, d, pb, s1, t0);
    chk(d == 8'h5A, "R7 held byte unchanged", d, 8'h5A);
    expect_quiet(900, "R6 single entry only");
  endtask

  task automatic t_break_disable;
    logic [7:0] d; logic pb, s1; int t0;
    uart_en = 1'b1; line_ctl = 7'h71;
    @(negedge clk);
    chk(tx_out == 1'b0, "R9 break low when idle", tx_out, 0);
    uart_en = 1'b0;
    @(negedge clk);
    chk(tx_out == 1'b0, "R9 break low when disabled", tx_out, 0);
    line_ctl = 7'h70;
    put(8'h96);
    expect_quiet(2000, "R10 no frame while disabled");
    chk(tx_busy == 1'b1, "R8 busy with stored byte", tx_busy, 1);
    uart_en = 1'b1;
    rx_frame(8, 0, d, pb, s1, t0);
    chk(d == 8'h96, "R10 queued byte kept", d, 8'h96);
    repeat (100) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_wlen_parity();
    t_stops();
    t_queue16();
    t_hold();
    t_break_disable();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule